// File: doc/BRIEF.md
# Coefficient Bank Swap Addresser

This block produces the read address sequence for a 128-entry coefficient store that feeds a multi-tap FIR engine. The engine can run one filter or two filters (A and B) side by side. A two-bit length code sets the number of taps per filter. Each filter may keep two coefficient sets, a lower bank and an upper bank, so that every coefficient can be replaced at once by selecting the other bank.

The bank request comes either from an external pin or from a software-held bit. A source-select input chooses between them. A request is only taken at a sample boundary, which the `samp_stb` pulse marks. On that pulse the block also latches the mode and length, and restarts its tap counter. On the following cycles it walks through every address of the selected bank, in dual mode A's taps then B's taps. It then idles until the next strobe.

The memory layout changes with length and mode. In single mode the upper bank sits directly above the lower bank. In dual mode the groups are stored as A lower, B lower, A upper, B upper. The longest length code fills the whole store and offers no swap.

Top module: `cbs_bank_addresser`

## Requirements
- R1: While `rst_n` is low and after its release, before any strobe, `coef_vld`, `active_bank` and `tap_is_b` are 0 and `coef_addr` is 0.
- R2: With `swap_src`=1 the bank request is `swap_reg`; with `swap_src`=0 it is `swap_pin`. A request of 0 selects the lower bank (`active_bank`=0) and a request of 1 selects the upper bank (`active_bank`=1).
- R3: `active_bank` takes a new value only in the cycle after a cycle with `samp_stb` high. Changes on `swap_pin`, `swap_reg`, `swap_src`, `tap_sel` or `dual_mode` between strobes do not alter `active_bank` or the address sequence in progress.
- R4: Length code `tap_sel`: in single mode (`dual_mode`=0) the values 0,1,2,3 mean 16,32,64,128 taps. In dual mode (`dual_mode`=1) they mean 8,16,32,64 taps per filter. One sample therefore spans N = 16 << `tap_sel` addresses in either mode.
- R5: In the N cycles after a strobe cycle, `coef_vld` is 1. `coef_addr` counts up by one each cycle, starting at base 0 for the lower bank or base N for the upper bank.
- R6: Single mode with T taps: the lower bank occupies 0..T-1 and the upper bank occupies T..2T-1.
- R7: Dual mode with T taps per filter: groups of T are ordered A lower, B lower, A upper, B upper. `tap_is_b` is 1 exactly while B's taps are addressed, which is the second half of each sample. It is always 0 in single mode.
- R8: With `tap_sel`=3 (single 128 or dual 64) any swap request is ignored. `active_bank` stays 0 and the addresses run 0..127.
- R9: A strobe that arrives while a sample is still in progress restarts the sequence at once. The new bank, length and mode apply from the next cycle.
- R10: After the N-th address, `coef_vld` drops to 0 and stays 0 until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_stb | input | 1 | One-cycle pulse marking a sample boundary |
| dual_mode | input | 1 | 0 = one filter, 1 = two filters A and B |
| tap_sel | input | 2 | Length code (see R4) |
| swap_pin | input | 1 | External bank request |
| swap_src | input | 1 | 0 = take request from pin, 1 = from register bit |
| swap_reg | input | 1 | Software-held bank request |
| coef_addr | output | 7 | Coefficient memory read address |
| coef_vld | output | 1 | Address is part of the current sample |
| active_bank | output | 1 | Bank in use (0 lower, 1 upper) |
| tap_is_b | output | 1 | Current address belongs to filter B |

## Verification
The checker watches four rules on every cycle:
- the bank holds steady between strobes;
- the bank stays low for the no-swap length code;
- addresses step by exactly one while a sample runs;
- the valid flag starts right after a strobe and stays low while idle.

The bench shows the rest by sweeping every combination of mode, length code, request source and request value. The exact base address of each layout, the filter-B flag position and the end-of-sample point can only be seen there. It also toggles the requests and configuration in mid-sample, and it restarts a sample early to show that a late strobe wins.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_REG = 1'b1
    } swap_src_e;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DUAL   = 1'b1
    } filt_mode_e;

endpackage

// File: rtl/cbs_span_dec.sv
// Decodes the length code into the per-bank span (addresses per sample)
// and whether a second bank fits in the store.
module cbs_span_dec #(
    parameter int ADDR_W  = 7,
    parameter int SEL_W   = 2,
    parameter int MIN_LOG = 3
) (
    input  logic [SEL_W-1:0] sel,
    output logic [ADDR_W:0]  span,
    output logic             swap_ok
);
    localparam logic [SEL_W-1:0] SEL_FULL = {SEL_W{1'b1}};
    localparam int               BASE_SH  = MIN_LOG + 1;

    always_comb begin
        span    = {{ADDR_W{1'b0}}, 1'b1} << (BASE_SH + int'(sel));
        swap_ok = (sel != SEL_FULL);
    end
endmodule

// File: rtl/cbs_swap_pick.sv
// Chooses the bank request source and masks it when no swap is possible.
module cbs_swap_pick
    import cbs_pkg::*;
(
    input  logic src,
    input  logic pin_req,
    input  logic reg_req,
    input  logic swap_ok,
    output logic bank_req
);
    swap_src_e src_e;

    always_comb begin
        src_e    = swap_src_e'(src);
        bank_req = swap_ok & ((src_e == SRC_REG) ? reg_req : pin_req);
    end
endmodule

// File: rtl/cbs_addr_gen.sv
// Maps the running tap count onto the memory layout: the upper bank is
// placed one span above the lower one, which yields both the single and
// the interleaved dual arrangement.
module cbs_addr_gen
    import cbs_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] cnt,
    input  logic              bank,
    input  logic              dual,
    input  logic [ADDR_W:0]   span,
    output logic [ADDR_W-1:0] addr,
    output logic              filt_b
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] cnt_ext;
    logic [EXT_W-1:0] half;
    logic [EXT_W-1:0] sum;
    filt_mode_e       mode_e;

    always_comb begin
        mode_e  = filt_mode_e'(dual);
        cnt_ext = {1'b0, cnt};
        half    = span >> 1;
        sum     = cnt_ext + (bank ? span : '0);
        addr    = sum[ADDR_W-1:0];
        filt_b  = (mode_e == MODE_DUAL) && (cnt_ext >= half);
    end
endmodule

// File: rtl/cbs_bank_addresser.sv
module cbs_bank_addresser
    import cbs_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int SEL_W   = 2,
    parameter int MIN_LOG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_stb,
    input  logic              dual_mode,
    input  logic [SEL_W-1:0]  tap_sel,
    input  logic              swap_pin,
    input  logic              swap_src,
    input  logic              swap_reg,
    output logic [ADDR_W-1:0] coef_addr,
    output logic              coef_vld,
    output logic              active_bank,
    output logic              tap_is_b
);
    localparam int EXT_W = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
        logic              run;
        logic              bank;
        logic [SEL_W-1:0]  sel;
        logic              dual;
    } state_t;

    state_t st_d, st_q;

    logic [EXT_W-1:0] span_in, span_q;
    logic             swap_ok_in, swap_ok_q;
    logic             bank_req;

    // capability of the configuration presented at the strobe
    cbs_span_dec #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .MIN_LOG(MIN_LOG)) u_dec_in (
        .sel     (tap_sel),
        .span    (span_in),
        .swap_ok (swap_ok_in)
    );

    // span of the configuration latched for the running sample
    cbs_span_dec #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .MIN_LOG(MIN_LOG)) u_dec_q (
        .sel     (st_q.sel),
        .span    (span_q),
        .swap_ok (swap_ok_q)
    );

    cbs_swap_pick u_pick (
        .src      (swap_src),
        .pin_req  (swap_pin),
        .reg_req  (swap_reg),
        .swap_ok  (swap_ok_in),
        .bank_req (bank_req)
    );

    cbs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .cnt    (st_q.cnt),
        .bank   (st_q.bank & swap_ok_q),
        .dual   (st_q.dual),
        .span   (span_q),
        .addr   (coef_addr),
        .filt_b (tap_is_b)
    );

    logic last_tap;

    always_comb begin
        st_d     = st_q;
        last_tap = ({1'b0, st_q.cnt} == (span_q - EXT_W'(1)));
        if (samp_stb) begin
            st_d.cnt  = '0;
            st_d.run  = 1'b1;
            st_d.bank = bank_req;
            st_d.sel  = tap_sel;
            st_d.dual = dual_mode;
        end else if (st_q.run) begin
            if (last_tap) begin
                st_d.run = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign coef_vld    = st_q.run;
    assign active_bank = st_q.bank;

    // span_in is used only for its width-matched decode of capability
    logic unused_span;
    assign unused_span = ^span_in;

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
    parameter int ADDR_W = 7,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              samp_stb,
    input logic              dual_mode,
    input logic [SEL_W-1:0]  tap_sel,
    input logic [ADDR_W-1:0] coef_addr,
    input logic              coef_vld,
    input logic              active_bank,
    input logic              tap_is_b
);
    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_stb |=> $stable(active_bank));

    p_no_swap_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_stb && tap_sel == {SEL_W{1'b1}}) |=> !active_bank);

    p_start_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |=> coef_vld);

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_vld && !samp_stb) |=>
            (!coef_vld || coef_addr == ADDR_W'($past(coef_addr) + 1'b1)));

    p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!coef_vld && !samp_stb) |=> !coef_vld);

    p_single_no_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_stb && !dual_mode) |=> !tap_is_b);
endmodule

bind cbs_bank_addresser cbs_checker #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .samp_stb    (samp_stb),
    .dual_mode   (dual_mode),
    .tap_sel     (tap_sel),
    .coef_addr   (coef_addr),
    .coef_vld    (coef_vld),
    .active_bank (active_bank),
    .tap_is_b    (tap_is_b)
);

// File: tb/test_cbs_bank_addresser.sv
module test_cbs_bank_addresser;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_stb = 1'b0;
    logic       dual_mode = 1'b0;
    logic [1:0] tap_sel = 2'd0;
    logic       swap_pin = 1'b0;
    logic       swap_src = 1'b0;
    logic       swap_reg = 1'b0;
    logic [6:0] coef_addr;
    logic       coef_vld;
    logic       active_bank;
    logic       tap_is_b;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    cbs_bank_addresser i_cbs_bank_addresser (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp_stb    (samp_stb),
        .dual_mode   (dual_mode),
        .tap_sel     (tap_sel),
        .swap_pin    (swap_pin),
        .swap_src    (swap_src),
        .swap_reg    (swap_reg),
        .coef_addr   (coef_addr),
        .coef_vld    (coef_vld),
        .active_bank (active_bank),
        .tap_is_b    (tap_is_b)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Drive one sample with the given configuration and check every address.
    task automatic run_sample(input bit d, input int s, input bit src, input bit rv);
        int  n;
        bit  eb;
        int  base;
        @(negedge clk);
        dual_mode = d;
        tap_sel   = 2'(s);
        swap_src  = src;
        // the unselected source carries the opposite value (R2)
        swap_reg  = src ? rv : ~rv;
        swap_pin  = src ? ~rv : rv;
        samp_stb  = 1'b1;
        n    = 16 << s;                 // R4
        eb   = (s != 3) && rv;          // R2, R8
        base = eb ? n : 0;
        @(negedge clk);
        samp_stb = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            check("R5 vld", int'(coef_vld), 1);
            check(d ? "R7 addr" : "R6 addr", int'(coef_addr), base + k);
            check(s == 3 ? "R8 bank" : "R2 bank", int'(active_bank), int'(eb));
            check("R7 tap_is_b", int'(tap_is_b), int'(d && (k >= n / 2)));
            // disturb every control input mid-sample (R3)
            swap_pin  = ~swap_pin;
            swap_reg  = ~swap_reg;
            swap_src  = ~swap_src;
            dual_mode = ~dual_mode;
            tap_sel   = tap_sel + 2'd1;
        end
        @(negedge clk);
        check("R10 vld drop", int'(coef_vld), 0);
        @(negedge clk);
        check("R10 vld idle", int'(coef_vld), 0);
        check("R3 bank held", int'(active_bank), int'(eb));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 vld", int'(coef_vld), 0);
        check("R1 bank", int'(active_bank), 0);
        check("R1 addr", int'(coef_addr), 0);
        check("R1 tap_is_b", int'(tap_is_b), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 vld after release", int'(coef_vld), 0);

        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 4; s++)
                for (int src = 0; src < 2; src++)
                    for (int rv = 0; rv < 2; rv++)
                        run_sample(bit'(d), s, bit'(src), bit'(rv));

        // R9: early strobe restarts with new configuration
        @(negedge clk);
        dual_mode = 1'b0; tap_sel = 2'd2; swap_src = 1'b1; swap_reg = 1'b0;
        samp_stb = 1'b1;
        @(negedge clk);
        samp_stb = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 mid addr", int'(coef_addr), 3);
        dual_mode = 1'b1; tap_sel = 2'd0; swap_src = 1'b0; swap_pin = 1'b1;
        samp_stb = 1'b1;
        @(negedge clk);
        samp_stb = 1'b0;
        check("R9 restart addr", int'(coef_addr), 16);
        check("R9 restart bank", int'(active_bank), 1);
        check("R9 restart b", int'(tap_is_b), 0);
        for (int k = 1; k < 16; k++) begin
            @(negedge clk);
            check("R9 addr", int'(coef_addr), 16 + k);
            check("R9 tap_is_b", int'(tap_is_b), int'(k >= 8));
        end
        @(negedge clk);
        check("R9 R10 end", int'(coef_vld), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule